// File: doc/BRIEF.md
# Speculative and Committed Register Rename Map

This block holds the register rename state for a core whose architectural and in-flight values share one physical storage array. It keeps two pointer tables, each indexed by architectural register number. The speculative table gives the newest physical pointer for every architectural register, together with a pending bit that marks a write still in flight. The committed table gives the pointer that holds the retired, architecturally visible value.

Rename writes a new pointer into the speculative table and returns the pointer it replaced, so that the pointer can travel with the instruction. Retirement changes only the committed table. No data moves, and the committed pointer that is displaced is returned so that it can go back to the free pool. A flush after a mispredicted branch or an interrupt copies the whole committed table into the speculative table in one cycle. Free-pool management and the value storage lie outside this block.

Top module: `rnm_map_top`

## Requirements
- R1: After reset, both tables map architectural register i to physical register i, and every pending bit is clear.
- R2: A rename with `ren_valid` high and `flush` low sets speculative entry `ren_arch` to `ren_phys` and sets its pending bit, from the next cycle on.
- R3: In the same cycle as a rename, `ren_prev_phys` shows the speculative pointer that `ren_arch` held before that rename.
- R4: Lookup ports are combinational and show the table state from before any update made in the current cycle.
- R5: A retirement (`ret_valid`) writes `ret_phys` into committed entry `ret_arch` and leaves every speculative pointer unchanged. In the same cycle `rel_valid` equals `ret_valid`, and `rel_phys` shows the committed pointer being displaced.
- R6: A retirement clears the pending bit of `ret_arch` only when that speculative pointer equals `ret_phys` and there is no rename of the same register in that cycle. Otherwise the bit is unchanged.
- R7: A flush makes every speculative pointer equal to the committed pointer and clears every pending bit, from the next cycle on.
- R8: When a flush and a retirement arrive in the same cycle, the retirement is applied first, and the restore copies the updated committed entry.
- R9: A rename in the same cycle as a flush is dropped: the flushed state alone holds afterwards.
- R10: Each of the `NUM_RD` lookup ports independently returns the speculative pointer and pending bit of the register it selects. Port k uses bits [k*AW +: AW] of `lkp_arch`, bits [k*PW +: PW] of `lkp_phys` and bit k of `lkp_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Architectural destination being renamed |
| ren_phys | input | PW | Newly allocated physical pointer |
| ren_prev_phys | output | PW | Speculative pointer replaced by the rename |
| ret_valid | input | 1 | Retirement request |
| ret_arch | input | AW | Architectural destination of the retiring instruction |
| ret_phys | input | PW | Physical pointer of the retiring instruction |
| rel_valid | output | 1 | A committed pointer is released this cycle |
| rel_phys | output | PW | Released (displaced) committed pointer |
| flush | input | 1 | Restore the speculative table from the committed table |
| lkp_arch | input | NUM_RD*AW | Architectural registers selected by the lookup ports |
| lkp_phys | output | NUM_RD*PW | Speculative pointers for the lookup ports |
| lkp_pend | output | NUM_RD | Pending bits for the lookup ports |

## Verification
The bench targets the cycles in which operations collide. In a flush that coincides with a retirement, a design that restored from the stale committed entry would bring back a pointer that is already free. A flush that coincides with a rename checks that the rename does not survive the flush. The pending-bit rules are tested with a retirement that is older than the latest rename of its register: a design that cleared the bit there would let readers take a value that has not been written yet. A long mixed stream, compared against a table model after every cycle, also catches a released pointer taken from the wrong table and lookups that leak a same-cycle update.

// File: rtl/rnm_pkg.sv
`timescale 1ns/1ps
package rnm_pkg;
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rnm_spec_table.sv
`timescale 1ns/1ps
module rnm_spec_table #(
   parameter int unsigned NUM_AREG = 8,
   parameter int unsigned NUM_PREG = 16,
   localparam int unsigned AW = rnm_pkg::idx_w(NUM_AREG),
   localparam int unsigned PW = rnm_pkg::idx_w(NUM_PREG)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ren_valid,
   input  logic [AW-1:0]                 ren_arch,
   input  logic [PW-1:0]                 ren_phys,
   input  logic                          ret_valid,
   input  logic [AW-1:0]                 ret_arch,
   input  logic [PW-1:0]                 ret_phys,
   input  logic                          flush,
   input  logic [NUM_AREG-1:0][PW-1:0]   restore_map,
   output logic [NUM_AREG-1:0][PW-1:0]   map,
   output logic [NUM_AREG-1:0]           pend
);
   for (genvar i = 0; i < NUM_AREG; i++) begin : g_ent
      logic [PW-1:0] ptr_q;
      logic          pend_q;
      logic          hit_ren;
      logic          hit_ret;

      assign hit_ren = ren_valid && (ren_arch == AW'(i));
      assign hit_ret = ret_valid && (ret_arch == AW'(i)) && (ptr_q == ret_phys);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q  <= PW'(i);
            pend_q <= 1'b0;
         end else if (flush) begin
            ptr_q  <= restore_map[i];
            pend_q <= 1'b0;
         end else if (hit_ren) begin
            ptr_q  <= ren_phys;
            pend_q <= 1'b1;
         end else if (hit_ret) begin
            pend_q <= 1'b0;
         end
      end

      assign map[i]  = ptr_q;
      assign pend[i] = pend_q;
   end
endmodule

// File: rtl/rnm_cmt_table.sv
`timescale 1ns/1ps
module rnm_cmt_table #(
   parameter int unsigned NUM_AREG = 8,
   parameter int unsigned NUM_PREG = 16,
   localparam int unsigned AW = rnm_pkg::idx_w(NUM_AREG),
   localparam int unsigned PW = rnm_pkg::idx_w(NUM_PREG)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ret_valid,
   input  logic [AW-1:0]                 ret_arch,
   input  logic [PW-1:0]                 ret_phys,
   output logic [NUM_AREG-1:0][PW-1:0]   map,
   output logic [NUM_AREG-1:0][PW-1:0]   next_map
);
   for (genvar i = 0; i < NUM_AREG; i++) begin : g_ent
      logic [PW-1:0] ptr_q;

      assign next_map[i] = (ret_valid && (ret_arch == AW'(i))) ? ret_phys : ptr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ptr_q <= PW'(i);
         else        ptr_q <= next_map[i];
      end

      assign map[i] = ptr_q;
   end
endmodule

// File: rtl/rnm_read_port.sv
`timescale 1ns/1ps
module rnm_read_port #(
   parameter int unsigned NUM_AREG = 8,
   parameter int unsigned NUM_PREG = 16,
   localparam int unsigned AW = rnm_pkg::idx_w(NUM_AREG),
   localparam int unsigned PW = rnm_pkg::idx_w(NUM_PREG)
) (
   input  logic [AW-1:0]                 arch,
   input  logic [NUM_AREG-1:0][PW-1:0]   map,
   input  logic [NUM_AREG-1:0]           pend_vec,
   output logic [PW-1:0]                 phys,
   output logic                          pend
);
   always_comb begin
      phys = '0;
      pend = 1'b0;
      for (int i = 0; i < NUM_AREG; i++) begin
         if (arch == AW'(i)) begin
            phys = map[i];
            pend = pend_vec[i];
         end
      end
   end
endmodule

// File: rtl/rnm_map_top.sv
`timescale 1ns/1ps
module rnm_map_top #(
   parameter int unsigned NUM_AREG = 8,
   parameter int unsigned NUM_PREG = 16,
   parameter int unsigned NUM_RD   = 2,
   localparam int unsigned AW = rnm_pkg::idx_w(NUM_AREG),
   localparam int unsigned PW = rnm_pkg::idx_w(NUM_PREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ren_valid,
   input  logic [AW-1:0]          ren_arch,
   input  logic [PW-1:0]          ren_phys,
   output logic [PW-1:0]          ren_prev_phys,
   input  logic                   ret_valid,
   input  logic [AW-1:0]          ret_arch,
   input  logic [PW-1:0]          ret_phys,
   output logic                   rel_valid,
   output logic [PW-1:0]          rel_phys,
   input  logic                   flush,
   input  logic [NUM_RD*AW-1:0]   lkp_arch,
   output logic [NUM_RD*PW-1:0]   lkp_phys,
   output logic [NUM_RD-1:0]      lkp_pend
);
   if (NUM_AREG < 2) begin : g_bad_areg
      $error("rnm_map_top: NUM_AREG must be at least 2");
   end
   if ((1 << AW) != NUM_AREG) begin : g_bad_pow2
      $error("rnm_map_top: NUM_AREG must be a power of two");
   end
   if (NUM_PREG <= NUM_AREG) begin : g_bad_preg
      $error("rnm_map_top: NUM_PREG must exceed NUM_AREG");
   end
   if (NUM_RD < 1) begin : g_bad_rd
      $error("rnm_map_top: NUM_RD must be at least 1");
   end

   logic [NUM_AREG-1:0][PW-1:0] spec_map;
   logic [NUM_AREG-1:0]         spec_pend;
   logic [NUM_AREG-1:0][PW-1:0] cmt_map;
   logic [NUM_AREG-1:0][PW-1:0] cmt_next;

   rnm_cmt_table #(.NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG)) u_cmt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ret_valid(ret_valid),
      .ret_arch (ret_arch),
      .ret_phys (ret_phys),
      .map      (cmt_map),
      .next_map (cmt_next)
   );

   rnm_spec_table #(.NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG)) u_spec (
      .clk        (clk),
      .rst_n      (rst_n),
      .ren_valid  (ren_valid),
      .ren_arch   (ren_arch),
      .ren_phys   (ren_phys),
      .ret_valid  (ret_valid),
      .ret_arch   (ret_arch),
      .ret_phys   (ret_phys),
      .flush      (flush),
      .restore_map(cmt_next),
      .map        (spec_map),
      .pend       (spec_pend)
   );

   for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
      rnm_read_port #(.NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG)) u_port (
         .arch    (lkp_arch[k*AW +: AW]),
         .map     (spec_map),
         .pend_vec(spec_pend),
         .phys    (lkp_phys[k*PW +: PW]),
         .pend    (lkp_pend[k])
      );
   end

   always_comb begin
      ren_prev_phys = '0;
      rel_phys      = '0;
      for (int i = 0; i < NUM_AREG; i++) begin
         if (ren_arch == AW'(i)) ren_prev_phys = spec_map[i];
         if (ret_arch == AW'(i)) rel_phys      = cmt_map[i];
      end
   end

   assign rel_valid = ret_valid;
endmodule

// File: rtl/rnm_map_chk.sv
`timescale 1ns/1ps
module rnm_map_chk #(
   parameter int unsigned NUM_AREG = 8,
   parameter int unsigned NUM_PREG = 16,
   localparam int unsigned AW = rnm_pkg::idx_w(NUM_AREG),
   localparam int unsigned PW = rnm_pkg::idx_w(NUM_PREG)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ren_valid,
   input logic [AW-1:0]               ren_arch,
   input logic [PW-1:0]               ren_phys,
   input logic                        ret_valid,
   input logic [AW-1:0]               ret_arch,
   input logic [PW-1:0]               ret_phys,
   input logic                        flush,
   input logic [NUM_AREG-1:0][PW-1:0] spec_map,
   input logic [NUM_AREG-1:0]         spec_pend,
   input logic [NUM_AREG-1:0][PW-1:0] cmt_map
);
   AST_REN_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid && !flush) |=> spec_map[$past(ren_arch)] == $past(ren_phys)); // R2
   AST_REN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid && !flush) |=> spec_pend[$past(ren_arch)]); // R2
   AST_RET_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> cmt_map[$past(ret_arch)] == $past(ret_phys)); // R5
   AST_RET_SPEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !ren_valid && !flush) |=> $stable(spec_map)); // R5
   AST_RET_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !flush && !(ren_valid && ren_arch == ret_arch)
       && spec_map[ret_arch] == ret_phys) |=> !spec_pend[$past(ret_arch)]); // R6
   AST_FLUSH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> spec_pend == '0); // R7
   AST_FLUSH_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> spec_map == cmt_map); // R8
endmodule

bind rnm_map_top rnm_map_chk #(.NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ren_valid(ren_valid),
   .ren_arch (ren_arch),
   .ren_phys (ren_phys),
   .ret_valid(ret_valid),
   .ret_arch (ret_arch),
   .ret_phys (ret_phys),
   .flush    (flush),
   .spec_map (spec_map),
   .spec_pend(spec_pend),
   .cmt_map  (cmt_map)
);

// File: tb/rnm_map_top_bench.sv
`timescale 1ns/1ps
module rnm_map_top_bench;
   localparam int NA = 8;
   localparam int NP = 16;
   localparam int NR = 2;
   localparam int AW = 3;
   localparam int PW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ren_valid = 1'b0;
   logic [AW-1:0]     ren_arch = '0;
   logic [PW-1:0]     ren_phys = '0;
   logic [PW-1:0]     ren_prev_phys;
   logic              ret_valid = 1'b0;
   logic [AW-1:0]     ret_arch = '0;
   logic [PW-1:0]     ret_phys = '0;
   logic              rel_valid;
   logic [PW-1:0]     rel_phys;
   logic              flush = 1'b0;
   logic [NR*AW-1:0]  lkp_arch = '0;
   logic [NR*PW-1:0]  lkp_phys;
   logic [NR-1:0]     lkp_pend;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int m_spec [NA];
   int m_pend [NA];
   int m_cmt  [NA];

   always #2 clk = ~clk;

   rnm_map_top #(.NUM_AREG(NA), .NUM_PREG(NP), .NUM_RD(NR)) u_rnm_map_top (.*);

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int a = 0; a < NA; a += 2) begin
         lkp_arch = {AW'(a + 1), AW'(a)};
         #0.1;
         check(req, $sformatf("port0 phys a%0d", a), int'(lkp_phys[0 +: PW]), m_spec[a]);
         check(req, $sformatf("port0 pend a%0d", a), int'(lkp_pend[0]), m_pend[a]);
         check(req, $sformatf("port1 phys a%0d", a + 1), int'(lkp_phys[PW +: PW]), m_spec[a + 1]);
         check(req, $sformatf("port1 pend a%0d", a + 1), int'(lkp_pend[1]), m_pend[a + 1]);
      end
   endtask

   task automatic step(input bit rv, input int ra, input int rp,
                       input bit tv, input int ta, input int tp, input bit fl);
      int nc [NA];
      ren_valid = rv; ren_arch = AW'(ra); ren_phys = PW'(rp);
      ret_valid = tv; ret_arch = AW'(ta); ret_phys = PW'(tp);
      flush = fl;
      lkp_arch = {AW'(ta), AW'(ra)};
      #0.1;
      check("R3", "ren_prev_phys", int'(ren_prev_phys), m_spec[ra]);
      check("R4", "same-cycle lookup", int'(lkp_phys[0 +: PW]), m_spec[ra]);
      check("R5", "rel_valid", int'(rel_valid), int'(tv));
      if (tv) check("R5", "rel_phys", int'(rel_phys), m_cmt[ta]);
      @(posedge clk);
      for (int a = 0; a < NA; a++) nc[a] = (tv && a == ta) ? tp : m_cmt[a];
      for (int a = 0; a < NA; a++) begin
         if (fl) begin
            m_spec[a] = nc[a]; m_pend[a] = 0;
         end else if (rv && a == ra) begin
            m_spec[a] = rp; m_pend[a] = 1;
         end else if (tv && a == ta && m_spec[a] == tp) begin
            m_pend[a] = 0;
         end
      end
      for (int a = 0; a < NA; a++) m_cmt[a] = nc[a];
      @(negedge clk);
      ren_valid = 1'b0; ret_valid = 1'b0; flush = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < NA; a++) begin m_spec[a] = a; m_cmt[a] = a; m_pend[a] = 0; end
      #9 rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");
      step(0, 0, 0, 0, 0, 0, 1);
      check_all("R1");                       // committed table also identity

      for (int a = 0; a < NA; a++) step(1, a, 8 + a, 0, 0, 0, 0);
      check_all("R2");

      for (int a = 0; a < 4; a++) step(0, a, 0, 1, a, 8 + a, 0);
      check_all("R6");
      check("R6", "a4 still pending", int'(m_pend[4]), 1);

      step(1, 5, 0, 0, 0, 0, 0);
      step(0, 5, 0, 1, 5, 13, 0);            // older retirement, newer rename
      check_all("R6");

      step(0, 0, 0, 0, 0, 0, 1);
      check_all("R7");

      step(1, 2, 1, 0, 0, 0, 0);
      step(0, 2, 0, 1, 6, 14, 1);            // flush together with retirement
      check_all("R8");
      check("R8", "model a6", m_spec[6], 14);

      step(1, 1, 15, 0, 0, 0, 1);            // rename dropped by flush
      check_all("R9");
      check("R9", "model a1", m_spec[1], 9);

      for (int n = 0; n < 400; n++) begin
         step(1'($urandom % 2), int'($urandom % NA), int'($urandom % NP),
              1'($urandom % 2), int'($urandom % NA), int'($urandom % NP),
              ($urandom % 12) == 0);
         check_all("R10");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule